// File: doc/BRIEF.md
# Sigma-Delta Converter Serial Host Controller

This block runs the host side of the serial port on a sigma-delta converter. The port has four wires: an active-low select, a serial clock, a data line from host to converter, and a data line from converter to host. The converter also drives an active-low ready line, which falls when it has a new conversion result.

The controller passes the ready line through a synchronizer. When it sees the line low, it opens one frame. In that frame it sends a command byte that points at the converter's data register and asks for a read. It then clocks in the 16-bit result and presents it on `result` with a one-cycle `result_valid` strobe.

A one-cycle configuration request does a different job. It opens a frame that writes a command byte for the setup register, followed by the caller's configuration byte. The converter's setup register comes up as 0x28 after its own reset.

Every interface time is built from the system clock. The select-to-clock lead, the clock high phase, the clock low phase and the data setup window are each given in picoseconds. They are turned into cycle counts at elaboration, rounded up so that no minimum is ever shortened.

Top module: `adc_serial_host`

## Requirements
- R1: After `sel_n` falls, the first rising edge of `sck` comes no sooner than ceil(T_CSS_PS/CLK_PS) system cycles (120 ns, 24 cycles by default).
- R2: Within a frame, every high phase of `sck` lasts at least ceil(T_HI_PS/CLK_PS) cycles and every low phase at least ceil(T_LO_PS/CLK_PS) cycles (20 cycles each by default).
- R3: `tx_bit` changes only at a falling edge of `sck`. It is therefore stable for at least ceil(T_DSU_PS/CLK_PS) cycles (6 by default) before each rising edge, and it does not move while `sck` is high inside a frame.
- R4: A read frame starts when `ready_n`, sampled through a two-flop synchronizer, is low. The frame first sends the command 0x38, MSB first. Its bit fields are: bits 7:6 = 00; bits 5:4 = register select, where 00 is communications, 01 is setup, 10 is test and 11 is data; bit 3 = 1 for read; bits 2:0 = 000. The frame then gives 16 more `sck` rising edges and samples `rx_bit` on each of them, MSB first.
- R5: `result_valid` is high for exactly one cycle per read frame, at the last rising edge of `sck`. `result` then holds the 16 sampled bits, first bit in bit 15.
- R6: A `cfg_req` pulse while idle sends the command 0x10 (select 01, bit 3 = 0 for write), then `cfg_byte` MSB first, for 16 clock edges in all. It does not raise `result_valid`.
- R7: If `cfg_req` and a synchronized low `ready_n` are seen in the same idle cycle, the configuration frame goes first and the read frame follows it.
- R8: A `cfg_req` that arrives while `busy` is high is ignored: no extra frame follows.
- R9: Only one read frame is made for each low period of `ready_n`. A new read waits until the line has been seen high and then low again.
- R10: In reset and between frames, `sel_n`, `sck` and `tx_bit` are high and `busy` is low. `busy` is high from the edge where `sel_n` falls to the edge where it rises.
- R11: A frame has exactly 24 (read) or 16 (write) rising edges of `sck`. `sel_n` rises only while `sck` is high and has been high for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ready_n | input | 1 | Converter result-ready, active low, asynchronous |
| rx_bit | input | 1 | Serial data from converter |
| cfg_req | input | 1 | One-cycle request to write the setup register |
| cfg_byte | input | CFG_W | Byte written to the setup register |
| sel_n | output | 1 | Converter port select, active low |
| sck | output | 1 | Serial clock, idles high |
| tx_bit | output | 1 | Serial data to converter, idles high |
| result | output | RES_W | Last conversion result |
| result_valid | output | 1 | One-cycle strobe when `result` is updated |
| busy | output | 1 | A frame is in progress |

## Verification
The configuration request and read detection can both fire in the same idle cycle. To provoke this, the bench drops `ready_n` and raises `cfg_req` two clock edges later, so the pulse meets the synchronizer output on the same edge. The collision is judged from the frames a bench model of the converter decodes. The first frame must carry 0x10 and the second 0x38, and the second must end with one `result_valid` carrying the posted word. The bench also places configuration requests in the middle of read frames and holds `ready_n` low past a read, to show that neither yields an extra frame.

// File: rtl/ash_pkg.sv
`timescale 1ns/1ps
package ash_pkg;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_LEAD,
      PH_LOW,
      PH_HIGH
   } phase_e;

   localparam logic [1:0] SEL_COMM  = 2'b00;
   localparam logic [1:0] SEL_SETUP = 2'b01;
   localparam logic [1:0] SEL_TEST  = 2'b10;
   localparam logic [1:0] SEL_DATA  = 2'b11;

   function automatic logic [7:0] cmd_byte(input logic [1:0] sel, input logic rd);
      return {2'b00, sel, rd, 3'b000};
   endfunction

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ash_sync.sv
`timescale 1ns/1ps
module ash_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("ash_sync needs at least two stages");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= RST_VAL;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/ash_tick.sv
`timescale 1ns/1ps
module ash_tick #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         done
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);

   assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !load && !done |=> !load || ($past(cnt) != cnt))
      else $error("timer stalled");

endmodule

// File: rtl/adc_serial_host.sv
`timescale 1ns/1ps
module adc_serial_host
   import ash_pkg::*;
#(
   parameter int CLK_PS      = 5000,
   parameter int T_CSS_PS    = 120000,
   parameter int T_HI_PS     = 100000,
   parameter int T_LO_PS     = 100000,
   parameter int T_DSU_PS    = 30000,
   parameter int T_ACC_PS    = 100000,
   parameter int RES_W       = 16,
   parameter int CFG_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ready_n,
   input  logic             rx_bit,
   input  logic             cfg_req,
   input  logic [CFG_W-1:0] cfg_byte,
   output logic             sel_n,
   output logic             sck,
   output logic             tx_bit,
   output logic [RES_W-1:0] result,
   output logic             result_valid,
   output logic             busy
);

   localparam int CMD_W     = 8;
   localparam int SETUP_CYC = ceil_div(T_CSS_PS, CLK_PS);
   localparam int HI_CYC    = ceil_div(T_HI_PS, CLK_PS);
   localparam int LO_CYC    = ceil_div(T_LO_PS, CLK_PS);
   localparam int DSU_CYC   = ceil_div(T_DSU_PS, CLK_PS);
   localparam int MAX_CYC   = max_of(SETUP_CYC, max_of(HI_CYC, LO_CYC));
   localparam int CNT_W     = $clog2(MAX_CYC + 1);
   localparam int RD_BITS   = CMD_W + RES_W;
   localparam int WR_BITS   = CMD_W + CFG_W;
   localparam int BIT_W     = $clog2(max_of(RD_BITS, WR_BITS) + 1);
   localparam int TX_W      = CMD_W + CFG_W;
   localparam int RUN_W     = CNT_W + 1;

   generate
      if (RES_W < 2) begin : g_bad_res
         $error("RES_W must be at least 2");
      end
      if (SETUP_CYC < 1 || HI_CYC < 1 || LO_CYC < 1) begin : g_bad_time
         $error("every phase needs at least one cycle");
      end
      if (LO_CYC < DSU_CYC) begin : g_bad_setup
         $error("low phase shorter than data setup window");
      end
      if (LO_CYC * CLK_PS < T_ACC_PS) begin : g_bad_access
         $error("low phase shorter than converter output delay");
      end
   endgenerate

   phase_e             st;
   logic               rdy_s_n;
   logic               armed;
   logic               is_rd;
   logic [BIT_W-1:0]   bits_left;
   logic [TX_W-1:0]    tx_sh;
   logic [RES_W-1:0]   rx_sh;
   logic               tmr_load;
   logic [CNT_W-1:0]   tmr_val;
   logic               tmr_done;
   logic               start_cfg;
   logic               start_rd;
   logic               frame_end;

   ash_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (ready_n),
      .dout (rdy_s_n)
   );

   ash_tick #(.W(CNT_W)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .load (tmr_load),
      .val  (tmr_val),
      .done (tmr_done)
   );

   assign start_cfg = (st == PH_IDLE) && cfg_req;
   assign start_rd  = (st == PH_IDLE) && !cfg_req && armed && !rdy_s_n;
   assign frame_end = (st == PH_HIGH) && tmr_done && (bits_left == '0);

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (st)
         PH_IDLE: begin
            tmr_load = start_cfg || start_rd;
            tmr_val  = CNT_W'(SETUP_CYC - 1);
         end
         PH_LEAD: begin
            tmr_load = tmr_done;
            tmr_val  = CNT_W'(LO_CYC - 1);
         end
         PH_LOW: begin
            tmr_load = tmr_done;
            tmr_val  = CNT_W'(HI_CYC - 1);
         end
         PH_HIGH: begin
            tmr_load = tmr_done && !frame_end;
            tmr_val  = CNT_W'(LO_CYC - 1);
         end
         default: begin
            tmr_load = 1'b0;
            tmr_val  = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= PH_IDLE;
         sel_n        <= 1'b1;
         sck          <= 1'b1;
         tx_bit       <= 1'b1;
         armed        <= 1'b1;
         is_rd        <= 1'b0;
         bits_left    <= '0;
         tx_sh        <= '1;
         rx_sh        <= '0;
         result       <= '0;
         result_valid <= 1'b0;
      end else begin
         result_valid <= 1'b0;
         if (rdy_s_n) armed <= 1'b1;
         unique case (st)
            PH_IDLE: begin
               if (start_cfg) begin
                  tx_sh     <= {cmd_byte(SEL_SETUP, 1'b0), cfg_byte};
                  is_rd     <= 1'b0;
                  bits_left <= BIT_W'(WR_BITS);
                  sel_n     <= 1'b0;
                  st        <= PH_LEAD;
               end else if (start_rd) begin
                  tx_sh     <= {cmd_byte(SEL_DATA, 1'b1), {CFG_W{1'b1}}};
                  is_rd     <= 1'b1;
                  armed     <= 1'b0;
                  bits_left <= BIT_W'(RD_BITS);
                  sel_n     <= 1'b0;
                  st        <= PH_LEAD;
               end
            end
            PH_LEAD: begin
               if (tmr_done) begin
                  sck    <= 1'b0;
                  tx_bit <= tx_sh[TX_W-1];
                  tx_sh  <= {tx_sh[TX_W-2:0], 1'b1};
                  st     <= PH_LOW;
               end
            end
            PH_LOW: begin
               if (tmr_done) begin
                  sck       <= 1'b1;
                  bits_left <= bits_left - 1'b1;
                  if (is_rd && bits_left <= BIT_W'(RES_W)) begin
                     rx_sh <= {rx_sh[RES_W-2:0], rx_bit};
                     if (bits_left == BIT_W'(1)) begin
                        result       <= {rx_sh[RES_W-2:0], rx_bit};
                        result_valid <= 1'b1;
                     end
                  end
                  st <= PH_HIGH;
               end
            end
            PH_HIGH: begin
               if (frame_end) begin
                  sel_n  <= 1'b1;
                  tx_bit <= 1'b1;
                  st     <= PH_IDLE;
               end else if (tmr_done) begin
                  sck    <= 1'b0;
                  tx_bit <= tx_sh[TX_W-1];
                  tx_sh  <= {tx_sh[TX_W-2:0], 1'b1};
                  st     <= PH_LOW;
               end
            end
            default: st <= PH_IDLE;
         endcase
      end
   end

   assign busy = (st != PH_IDLE);

   // run-length counters that exist only for the timing properties below
   logic [RUN_W-1:0] lo_run;
   logic [RUN_W-1:0] hi_run;
   logic [RUN_W-1:0] lead_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_run   <= '0;
         hi_run   <= '0;
         lead_run <= '0;
      end else begin
         lo_run   <= sck   ? '0 : ((lo_run   == '1) ? lo_run   : lo_run   + 1'b1);
         hi_run   <= !sck  ? '0 : ((hi_run   == '1) ? hi_run   : hi_run   + 1'b1);
         lead_run <= sel_n ? '0 : ((lead_run == '1) ? lead_run : lead_run + 1'b1);
      end
   end

   assert_lead_time_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck) && !sel_n |-> lead_run >= RUN_W'(SETUP_CYC))
      else $error("select lead too short");

   assert_low_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck) |-> lo_run >= RUN_W'(LO_CYC))
      else $error("clock low phase too short");

   assert_high_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sck) |-> hi_run >= RUN_W'(HI_CYC))
      else $error("clock high phase too short");

   assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_n && sck && $past(sck) |-> $stable(tx_bit))
      else $error("data moved while clock high");

   assert_one_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid)
      else $error("valid strobe longer than one cycle");

   assert_valid_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> !sel_n && $rose(sck))
      else $error("valid strobe outside a rising clock edge");

   assert_idle_levels_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n |-> sck && tx_bit && !busy)
      else $error("idle levels wrong");

   assert_frame_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sel_n) |-> sck && $past(sck))
      else $error("select released outside clock high");

endmodule

// File: tb/tb_adc_serial_host.sv
`timescale 1ns/1ps
module tb_adc_serial_host;

   localparam int SETUP_MIN = (120 + 4) / 5;
   localparam int HI_MIN    = (100 + 4) / 5;
   localparam int LO_MIN    = (100 + 4) / 5;
   localparam int DSU_MIN   = (30 + 4) / 5;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        ready_n = 1'b1;
   logic        rx_bit = 1'b0;
   logic        cfg_req;
   logic [7:0]  cfg_byte;
   logic        sel_n, sck, tx_bit, result_valid, busy;
   logic [15:0] result;

   always #2.5 clk = ~clk;

   adc_serial_host dut (
      .clk(clk), .rst_n(rst_n), .ready_n(ready_n), .rx_bit(rx_bit),
      .cfg_req(cfg_req), .cfg_byte(cfg_byte), .sel_n(sel_n), .sck(sck),
      .tx_bit(tx_bit), .result(result), .result_valid(result_valid), .busy(busy)
   );

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   // stimulus-side controls (written only by tasks)
   int          req_cnt = 0;
   int          rel_cnt = 0;
   logic [15:0] word_in = '0;
   bit          hold_rdy = 1'b0;

   // converter model state (written only by the model)
   int          req_seen = 0, rel_seen = 0;
   logic [15:0] cur_word = '0;
   logic        p_sel = 1'b1, p_sck = 1'b1, p_tx = 1'b1;
   int          lead = 0, lo_c = 0, hi_c = 0, tx_age = 0, bitc = 0;
   bit          chg_hi = 1'b0;
   logic [7:0]  cmd = '0;
   logic [15:0] wdat = '0;
   int          frames = 0, valid_cnt = 0, last_bits = 0;
   logic [7:0]  last_cmd = '0, prev_cmd = '0;
   logic [15:0] last_dat = '0, last_res = '0;

   always @(negedge clk) begin
      if (req_cnt != req_seen) begin
         req_seen = req_cnt;
         cur_word = word_in;
         ready_n  = 1'b0;
      end
      if (rel_cnt != rel_seen) begin
         rel_seen = rel_cnt;
         ready_n  = 1'b1;
      end
      if (result_valid) begin
         valid_cnt++;
         last_res = result;
      end
      if (p_sel && !sel_n) begin
         bitc = 0; lead = 0; cmd = '0; wdat = '0;
      end else if (!sel_n) begin
         lead++;
      end
      if (tx_bit != p_tx) begin
         tx_age = 0;
         if (sck && p_sck && !sel_n) chg_hi = 1'b1;
      end else begin
         tx_age++;
      end
      if (!sel_n && !p_sck && sck) begin
         if (bitc == 0) chk(lead >= SETUP_MIN, "R1", "select lead cycles", lead, SETUP_MIN);
         chk(lo_c >= LO_MIN, "R2", "low phase cycles", lo_c, LO_MIN);
         chk(tx_age >= DSU_MIN, "R3", "data setup cycles", tx_age, DSU_MIN);
         if (bitc < 8) cmd = {cmd[6:0], tx_bit};
         else          wdat = {wdat[14:0], tx_bit};
         bitc++;
         hi_c = 1;
         chg_hi = 1'b0;
      end else if (sck) begin
         hi_c++;
      end
      if (!sel_n && p_sck && !sck) begin
         if (bitc > 0) begin
            chk(hi_c >= HI_MIN, "R2", "high phase cycles", hi_c, HI_MIN);
            chk(!chg_hi, "R3", "data change while clock high", chg_hi, 0);
         end
         lo_c = 1;
         if (cmd == 8'h38 && bitc >= 8 && bitc < 24) rx_bit = cur_word[23 - bitc];
         if (cmd == 8'h38 && bitc == 9 && !hold_rdy) ready_n = 1'b1;
      end else if (!sck) begin
         lo_c++;
      end
      if (!p_sel && sel_n) begin
         frames++;
         prev_cmd  = last_cmd;
         last_cmd  = cmd;
         last_dat  = wdat;
         last_bits = bitc;
      end
      p_sel = sel_n; p_sck = sck; p_tx = tx_bit;
   end

   task automatic wait_frames(input int target);
      while (frames < target) @(posedge clk);
   endtask

   task automatic check_idle(input string tag);
      chk(sel_n == 1'b1, tag, "idle select", sel_n, 1);
      chk(sck == 1'b1 && tx_bit == 1'b1, tag, "idle clock/data", {sck, tx_bit}, 2'b11);
      chk(busy == 1'b0, tag, "idle busy", busy, 0);
   endtask

   task automatic post_word(input logic [15:0] w);
      @(posedge clk); #1;
      word_in = w;
      req_cnt++;
   endtask

   task automatic do_read(input logic [15:0] w);
      int f0 = frames;
      int v0 = valid_cnt;
      post_word(w);
      wait_frames(f0 + 1);
      repeat (4) @(posedge clk);
      #1;
      chk(last_cmd == 8'h38, "R4", "read command byte", last_cmd, 8'h38);
      chk(last_bits == 24, "R11", "read clock edges", last_bits, 24);
      chk(valid_cnt == v0 + 1, "R5", "valid pulses", valid_cnt - v0, 1);
      chk(last_res == w, "R5", "result word", last_res, w);
      check_idle("R10");
   endtask

   task automatic do_cfg(input logic [7:0] b);
      int f0 = frames;
      int v0 = valid_cnt;
      @(posedge clk); #1;
      cfg_byte = b;
      cfg_req  = 1'b1;
      @(posedge clk); #1;
      cfg_req  = 1'b0;
      chk(busy == 1'b1 && sel_n == 1'b0, "R10", "busy in frame", {busy, sel_n}, 2'b10);
      wait_frames(f0 + 1);
      repeat (4) @(posedge clk);
      #1;
      chk(last_cmd == 8'h10, "R6", "setup command byte", last_cmd, 8'h10);
      chk(last_dat[7:0] == b, "R6", "setup data byte", last_dat[7:0], b);
      chk(last_bits == 16, "R11", "write clock edges", last_bits, 16);
      chk(valid_cnt == v0, "R6", "no valid on write", valid_cnt - v0, 0);
      check_idle("R10");
   endtask

   initial begin
      int f0;
      int v0;
      logic [15:0] w;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; cfg_req = 1'b0; cfg_byte = '0;
      repeat (5) @(posedge clk);
      #1;
      check_idle("R10");
      chk(result_valid == 1'b0 && result == '0, "R10", "reset result", {result_valid, result}, 0);
      rst_n = 1'b1;
      repeat (5) @(posedge clk);

      // directed reads
      do_read(16'h0000);
      do_read(16'hFFFF);
      do_read(16'h8001);
      do_read(16'h7FFE);
      do_cfg(8'h28);
      do_cfg(8'h00);
      do_cfg(8'hFF);

      // random mix
      for (int i = 0; i < 24; i++) begin
         if ($urandom % 3 == 0) do_cfg(8'($urandom));
         else                   do_read(16'($urandom));
      end

      // R7: request and synchronized ready land on the same edge
      f0 = frames; v0 = valid_cnt; w = 16'hC35A;
      post_word(w);
      @(posedge clk);
      @(posedge clk); #1;
      cfg_byte = 8'h5C; cfg_req = 1'b1;
      @(posedge clk); #1;
      cfg_req = 1'b0;
      wait_frames(f0 + 2);
      repeat (4) @(posedge clk);
      #1;
      chk(prev_cmd == 8'h10, "R7", "first frame is setup write", prev_cmd, 8'h10);
      chk(last_cmd == 8'h38, "R7", "second frame is read", last_cmd, 8'h38);
      chk(last_res == w && valid_cnt == v0 + 1, "R7", "read after collision", last_res, w);

      // R8: request in the middle of a read frame
      f0 = frames; w = 16'h1E2D;
      post_word(w);
      while (!busy) @(posedge clk);
      repeat (100) @(posedge clk);
      #1;
      cfg_byte = 8'hA7; cfg_req = 1'b1;
      @(posedge clk); #1;
      cfg_req = 1'b0;
      wait_frames(f0 + 1);
      repeat (300) @(posedge clk);
      #1;
      chk(frames == f0 + 1, "R8", "frames after busy request", frames - f0, 1);
      chk(last_cmd == 8'h38 && last_res == w, "R8", "read unaffected", last_res, w);
      check_idle("R8");

      // R9: ready held low past a read
      hold_rdy = 1'b1;
      f0 = frames; v0 = valid_cnt; w = 16'h6B19;
      post_word(w);
      wait_frames(f0 + 1);
      repeat (500) @(posedge clk);
      #1;
      chk(frames == f0 + 1, "R9", "frames while ready stays low", frames - f0, 1);
      chk(valid_cnt == v0 + 1, "R9", "valid pulses while ready low", valid_cnt - v0, 1);
      hold_rdy = 1'b0;
      rel_cnt++;
      repeat (6) @(posedge clk);
      do_read(16'h9D04);
      chk(frames == f0 + 2, "R9", "read after re-arm", frames - f0, 2);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual frames %0d expected run to finish", frames);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule